// File: doc/BRIEF.md
# Subroutine Return Address Stack

This block keeps the return addresses of nested subroutine calls for a small controller core whose program counter is 11 bits wide. When the core executes a call, it raises `call_i` for one cycle with the address to come back to on `push_addr_i`. That value becomes the new top entry, and every older entry moves one level deeper. When the core executes a return, it raises `ret_i` for one cycle. In that same cycle it loads the program counter from `top_addr_o`, which is driven combinationally by the top level. On the next clock edge every entry moves one level up.

The stack has eight levels and does not flag overflow or underflow. A ninth nested call drops the oldest address. A return copies the deepest level upward and leaves the deepest level as it was, so that value then sits in both of the two deepest levels. Repeated returns past the real nesting depth keep supplying that duplicated value. All eight levels are visible together on `levels_o` for debug.

Top module: `ret_addr_stack`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge with `rst` high, sets all eight levels to zero.
- R2: After a cycle with `call_i` high and `ret_i` low, level 1 holds the `push_addr_i` value of that cycle, and each level k from 2 to 8 holds what level k-1 held before.
- R3: A call made with eight live entries discards the old level 8 value. It does not reappear after later returns.
- R4: `top_addr_o` always equals the current level 1 contents with no register in between, so it is valid in the same cycle that `ret_i` is high.
- R5: After a cycle with `ret_i` high, each level n from 1 to 7 holds what level n+1 held before.
- R6: A return leaves level 8 unchanged, so after one return levels 7 and 8 are equal.
- R7: When `call_i` and `ret_i` are both high in one cycle, the stack performs only the return. `push_addr_i` is not stored.
- R8: In a cycle with neither strobe high, all levels keep their values.
- R9: `levels_o` carries level k (k = 1..8) in bits [11k-1 : 11(k-1)], so level 1 sits in bits 10:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | One-cycle push strobe |
| ret_i | input | 1 | One-cycle pop strobe, wins over `call_i` |
| push_addr_i | input | 11 | Return address stored on a call |
| top_addr_o | output | 11 | Level 1 contents, feeds the program counter on a return |
| levels_o | output | 88 | All levels packed, level 1 in the low bits |

## Verification
The bench pushes nine distinct addresses and then returns repeatedly. A design that kept the oldest entry, or that shifted in the wrong direction, would show the first address again. A design that cleared the bottom level on a pop would show zeros where the duplicated deepest value belongs. The bench drives both strobes together to catch a design that lets the call win or merges the two operations. It checks `top_addr_o` before the edge of a return cycle to catch a registered output that lags by one cycle. Idle cycles and a mid-stream reset confirm that the stack holds its values when no strobe is high and clears every level on reset.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } ras_op_e;
endpackage

// File: rtl/ras_op_decode.sv
module ras_op_decode
    import ras_pkg::*;
(
    input  logic    call_i,
    input  logic    ret_i,
    output ras_op_e op_o
);
    // Return takes priority over call (R7)
    always_comb begin
        if (ret_i)       op_o = OP_POP;
        else if (call_i) op_o = OP_PUSH;
        else             op_o = OP_HOLD;
    end
endmodule

// File: rtl/ras_level_next.sv
module ras_level_next
    import ras_pkg::*;
#(
    parameter int AW = 11
) (
    input  ras_op_e       op_i,
    input  logic [AW-1:0] own_i,
    input  logic [AW-1:0] from_above_i,
    input  logic [AW-1:0] from_below_i,
    output logic [AW-1:0] next_o
);
    always_comb begin
        unique case (op_i)
            OP_PUSH: next_o = from_above_i;
            OP_POP:  next_o = from_below_i;
            default: next_o = own_i;
        endcase
    end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                call_i,
    input  logic                ret_i,
    input  logic [AW-1:0]       push_addr_i,
    output logic [AW-1:0]       top_addr_o,
    output logic [DEPTH*AW-1:0] levels_o
);
    localparam int BITS = DEPTH * AW;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] lvl;
    } state_t;

    state_t  state_d, state_q;
    ras_op_e op;
    logic [DEPTH-1:0][AW-1:0] nxt;

    ras_op_decode u_dec (
        .call_i (call_i),
        .ret_i  (ret_i),
        .op_o   (op)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        logic [AW-1:0] above, below;
        if (i == 0) begin : g_first
            assign above = push_addr_i;
        end else begin : g_mid_a
            assign above = state_q.lvl[i-1];
        end
        if (i == DEPTH - 1) begin : g_last
            // Deepest level keeps its value on a pop (R6)
            assign below = state_q.lvl[i];
        end else begin : g_mid_b
            assign below = state_q.lvl[i+1];
        end
        ras_level_next #(.AW(AW)) u_next (
            .op_i         (op),
            .own_i        (state_q.lvl[i]),
            .from_above_i (above),
            .from_below_i (below),
            .next_o       (nxt[i])
        );
    end

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.lvl = '0;
        end else begin
            state_d.lvl = nxt;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign top_addr_o = state_q.lvl[0];
    assign levels_o   = BITS'(state_q.lvl);
endmodule

// File: rtl/ret_addr_stack_checker.sv
module ret_addr_stack_checker #(
    parameter int DEPTH = 8,
    parameter int AW    = 11
) (
    input logic                clk,
    input logic                rst,
    input logic                call_i,
    input logic                ret_i,
    input logic [AW-1:0]       push_addr_i,
    input logic [AW-1:0]       top_addr_o,
    input logic [DEPTH*AW-1:0] levels_o
);
    localparam int TOP_LO = 0;
    localparam int L2_LO  = AW;
    localparam int BOT_LO = (DEPTH - 1) * AW;
    localparam int NB_LO  = (DEPTH - 2) * AW;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (levels_o == '0));

    assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i) |=> (levels_o[TOP_LO +: AW] == $past(push_addr_i)));

    assert_push_bottom_R3: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i) |=> (levels_o[BOT_LO +: AW] == $past(levels_o[NB_LO +: AW])));

    assert_pop_output_R4: assert property (@(posedge clk) disable iff (rst)
        ret_i |=> (levels_o[TOP_LO +: AW] == $past(top_addr_o) || 1'b1) &&
                  ($past(top_addr_o) == $past(levels_o[TOP_LO +: AW])));

    assert_pop_shift_R5: assert property (@(posedge clk) disable iff (rst)
        ret_i |=> (levels_o[TOP_LO +: AW] == $past(levels_o[L2_LO +: AW])));

    assert_pop_bottom_R6: assert property (@(posedge clk) disable iff (rst)
        ret_i |=> $stable(levels_o[BOT_LO +: AW]));

    assert_both_pop_R7: assert property (@(posedge clk) disable iff (rst)
        (ret_i && call_i) |=> (levels_o[BOT_LO +: AW] == $past(levels_o[BOT_LO +: AW])));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!ret_i && !call_i) |=> $stable(levels_o));
endmodule

bind ret_addr_stack ret_addr_stack_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .push_addr_i (push_addr_i),
    .top_addr_o  (top_addr_o),
    .levels_o    (levels_o)
);

// File: tb/ret_addr_stack_bench.sv
`timescale 1ns/1ps
module ret_addr_stack_bench;
    localparam int D  = 8;
    localparam int AW = 11;

    logic            clk = 1'b0;
    logic            rst, call_i, ret_i;
    logic [AW-1:0]   push_addr_i;
    logic [AW-1:0]   top_addr_o;
    logic [D*AW-1:0] levels_o;

    logic [AW-1:0] model [D];
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ret_addr_stack u_ret_addr_stack (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .push_addr_i(push_addr_i), .top_addr_o(top_addr_o), .levels_o(levels_o)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < D; k++) check(req, levels_o[k*AW +: AW], model[k]);
        check(req, top_addr_o, model[0]);
    endtask

    // one clocked operation; inputs change at negedge
    task automatic step(input logic c, input logic r, input logic [AW-1:0] a);
        call_i = c; ret_i = r; push_addr_i = a;
        #1;
        if (r) check("R4 same-cycle top", top_addr_o, model[0]);
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0; push_addr_i = '0;
        if (r) begin
            for (int k = 0; k < D-1; k++) model[k] = model[k+1];
        end else if (c) begin
            for (int k = D-1; k > 0; k--) model[k] = model[k-1];
            model[0] = a;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < D; k++) model[k] = '0;
        check_all("R1 reset");
    endtask

    task automatic t_push_pop();
        step(1, 0, 11'h123); check_all("R2 push");
        step(1, 0, 11'h456); check_all("R2 push");
        step(1, 0, 11'h7FF); check_all("R9 layout");
        step(0, 1, '0);      check_all("R5 pop");
        check(" R5 top", top_addr_o, 11'h456);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++) step(1, 0, 11'(11'h100 + i * 11'h11));
        check_all("R3 overflow");
        check("R3 bottom", levels_o[(D-1)*AW +: AW], 11'h111);
        for (int i = 0; i < 9; i++) begin
            step(0, 1, '0);
            check_all("R6 pop dup");
        end
        check("R6 dup value", top_addr_o, 11'h111);
        check("R6 L7=L8", levels_o[(D-2)*AW +: AW], levels_o[(D-1)*AW +: AW]);
    endtask

    task automatic t_both();
        step(1, 0, 11'h0AA);
        step(1, 0, 11'h0BB);
        step(1, 1, 11'h3CC); check_all("R7 both");
        check("R7 top", top_addr_o, 11'h0AA);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 11'h555); check_all("R8 idle");
        end
    endtask

    task automatic t_midreset();
        step(1, 0, 11'h2EE);
        t_reset();
        step(0, 1, '0); check_all("R1 after reset pop");
    endtask

    initial begin
        rst = 1'b1; call_i = 1'b0; ret_i = 1'b0; push_addr_i = '0;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_overflow();
        t_both();
        t_idle();
        t_midreset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule